// File: doc/BRIEF.md
# Iterative Byte-Sliced 16x16 Multiplier

This block multiplies two 16-bit operands and returns the full 32-bit product. The operands can be treated as unsigned or as two's complement numbers. It contains a single 8x8 unsigned multiplier, which it reuses over several clock cycles. Each operand is split into a low byte and a high byte. The block forms the four byte-by-byte partial products one per clock and accumulates them into a 32-bit result register. When the operands are signed, the block then applies up to two subtractive corrections to the upper 16 bits of the result.

To launch an operation, pulse `start` while the block is idle, with the operands and the mode bit on the inputs. The block takes a copy of the operands and the mode on that edge. It raises `busy` while it works and pulses `done` once the product is ready. The product then stays on the output unchanged until the next accepted start. The multiply reports no carry, zero, overflow or other status flags.

Top module: `bmul16_iter`

## Requirements
- R1: With `signed_mode` = 0 at the accepted start, `product` equals the unsigned product of `op_a` and `op_b`, both taken as 0..65535, whenever `done` is high.
- R2: With `signed_mode` = 1 at the accepted start, `product` equals the two's complement product of `op_a` and `op_b`, both taken as -32768..32767, as a 32-bit two's complement value whenever `done` is high.
- R3: A start is accepted on a rising edge where `start` = 1 and `busy` = 0. `done` goes high after the 4th rising edge that follows the accepted start in unsigned mode, and after the 6th in signed mode.
- R4: `busy` is high from the edge that accepts a start until the edge that raises `done`. It is low while `done` is high.
- R5: `done` is high for exactly one cycle. While the block is idle and no start is accepted, `product` keeps its value.
- R6: A `start` pulse while `busy` is high is ignored. The operation in progress keeps its operands, its mode and its timing.
- R7: `op_a`, `op_b` and `signed_mode` are sampled only on the accepting edge. Changing them during an operation does not change its result.
- R8: A synchronous active-high `rst` clears `product` to 0 and drives `busy` and `done` low on the next edge, even in the middle of an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch request, accepted only when idle |
| signed_mode | input | 1 | 1 = two's complement operands, 0 = unsigned |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: the product is ready |
| product | output | 32 | Result register |

## Verification
The hardest case to reach is a start request that arrives in the middle of an operation, at the same time as the operand inputs change. It only shows up as a wrong product if the block mistakenly accepts it. The stimulus covers this case in three ways. It scrambles the operands and inverts the mode immediately after every accepted start. It also issues a second start, with different operands, while the first operation is still running. A behavioural model in the bench ignores such starts, and it is compared against the design on every clock. The bench also applies a reset in the middle of a signed operation, so that it can see the result register being cleared while the corrections are pending.

// File: rtl/bmul_pkg.sv
package bmul_pkg;

    localparam int BYTE_W = 8;
    localparam int OP_W   = 2 * BYTE_W;
    localparam int RES_W  = 2 * OP_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LL,
        ST_HH,
        ST_LH,
        ST_HL,
        ST_FIX_B,
        ST_FIX_A
    } step_t;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_SET_LO,
        ACT_SET_HI,
        ACT_ADD_MID,
        ACT_SUB_HI
    } act_t;

    typedef struct packed {
        logic            smode;
        logic [OP_W-1:0] a;
        logic [OP_W-1:0] b;
    } job_t;

    typedef struct packed {
        act_t              act;
        logic [BYTE_W-1:0] mx;
        logic [BYTE_W-1:0] my;
        logic [OP_W-1:0]   sub;
    } step_ctl_t;

    function automatic logic [BYTE_W-1:0] lo_byte(input logic [OP_W-1:0] v);
        return v[BYTE_W-1:0];
    endfunction

    function automatic logic [BYTE_W-1:0] hi_byte(input logic [OP_W-1:0] v);
        return v[OP_W-1:BYTE_W];
    endfunction

    function automatic step_t next_step(input step_t s, input logic smode);
        case (s)
            ST_LL:    return ST_HH;
            ST_HH:    return ST_LH;
            ST_LH:    return ST_HL;
            ST_HL:    return smode ? ST_FIX_B : ST_IDLE;
            ST_FIX_B: return ST_FIX_A;
            default:  return ST_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/bmul_core.sv
module bmul_core #(
    parameter int W = 8
) (
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    output logic [2*W-1:0] p
);
    assign p = x * y;
endmodule

// File: rtl/bmul_seq.sv
module bmul_seq
    import bmul_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            smode_in,
    input  logic [OP_W-1:0] a_in,
    input  logic [OP_W-1:0] b_in,
    output step_t           step,
    output job_t            job,
    output logic            busy,
    output logic            done
);
    step_t step_nx;

    assign busy    = (step != ST_IDLE);
    assign step_nx = next_step(step, job.smode);

    always_ff @(posedge clk) begin
        if (rst) begin
            step <= ST_IDLE;
            job  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (step == ST_IDLE) begin
                if (start) begin
                    job  <= '{smode: smode_in, a: a_in, b: b_in};
                    step <= ST_LL;
                end
            end else begin
                step <= step_nx;
                if (step_nx == ST_IDLE) begin
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/bmul_acc.sv
module bmul_acc
    import bmul_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  act_t             act,
    input  logic [OP_W-1:0]  prod,
    input  logic [OP_W-1:0]  sub,
    output logic [RES_W-1:0] res
);
    localparam int MID_W = RES_W - BYTE_W;

    logic [MID_W-1:0] mid_sum;
    logic [OP_W-1:0]  hi_diff;

    assign mid_sum = res[RES_W-1:BYTE_W] + {{(MID_W-OP_W){1'b0}}, prod};
    assign hi_diff = res[RES_W-1:OP_W] - sub;

    always_ff @(posedge clk) begin
        if (rst) begin
            res <= '0;
        end else begin
            case (act)
                ACT_SET_LO:  res[OP_W-1:0]        <= prod;
                ACT_SET_HI:  res[RES_W-1:OP_W]    <= prod;
                ACT_ADD_MID: res[RES_W-1:BYTE_W]  <= mid_sum;
                ACT_SUB_HI:  res[RES_W-1:OP_W]    <= hi_diff;
                default:     res                  <= res;
            endcase
        end
    end
endmodule

// File: rtl/bmul16_iter.sv
module bmul16_iter
    import bmul_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             signed_mode,
    input  logic [OP_W-1:0]  op_a,
    input  logic [OP_W-1:0]  op_b,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] product
);
    step_t           step;
    job_t            job;
    step_ctl_t       ctl;
    logic [OP_W-1:0] pp;

    bmul_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .smode_in (signed_mode),
        .a_in     (op_a),
        .b_in     (op_b),
        .step     (step),
        .job      (job),
        .busy     (busy),
        .done     (done)
    );

    // Operand byte selection and action for each step
    always_comb begin
        ctl = '{act: ACT_HOLD, mx: '0, my: '0, sub: '0};
        case (step)
            ST_LL: begin
                ctl.act = ACT_SET_LO;
                ctl.mx  = lo_byte(job.a);
                ctl.my  = lo_byte(job.b);
            end
            ST_HH: begin
                ctl.act = ACT_SET_HI;
                ctl.mx  = hi_byte(job.a);
                ctl.my  = hi_byte(job.b);
            end
            ST_LH: begin
                ctl.act = ACT_ADD_MID;
                ctl.mx  = lo_byte(job.a);
                ctl.my  = hi_byte(job.b);
            end
            ST_HL: begin
                ctl.act = ACT_ADD_MID;
                ctl.mx  = hi_byte(job.a);
                ctl.my  = lo_byte(job.b);
            end
            ST_FIX_B: begin
                ctl.act = job.b[OP_W-1] ? ACT_SUB_HI : ACT_HOLD;
                ctl.sub = job.a;
            end
            ST_FIX_A: begin
                ctl.act = job.a[OP_W-1] ? ACT_SUB_HI : ACT_HOLD;
                ctl.sub = job.b;
            end
            default: ;
        endcase
    end

    bmul_core #(.W(BYTE_W)) u_core (
        .x (ctl.mx),
        .y (ctl.my),
        .p (pp)
    );

    bmul_acc u_acc (
        .clk  (clk),
        .rst  (rst),
        .act  (ctl.act),
        .prod (pp),
        .sub  (ctl.sub),
        .res  (product)
    );
endmodule

// File: rtl/bmul16_chk.sv
module bmul16_chk
    import bmul_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             signed_mode,
    input logic [OP_W-1:0]  op_a,
    input logic [OP_W-1:0]  op_b,
    input logic             busy,
    input logic             done,
    input logic [RES_W-1:0] product
);
    logic [3:0]       cnt;
    logic             smode_q;
    logic [RES_W-1:0] ref_q;

    function automatic logic [RES_W-1:0] full_mul(input logic [OP_W-1:0] a,
                                                   input logic [OP_W-1:0] b,
                                                   input logic s);
        logic [RES_W-1:0] xa, xb;
        xa = s ? {{OP_W{a[OP_W-1]}}, a} : {{OP_W{1'b0}}, a};
        xb = s ? {{OP_W{b[OP_W-1]}}, b} : {{OP_W{1'b0}}, b};
        return xa * xb;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            smode_q <= 1'b0;
            ref_q   <= '0;
        end else if (start && !busy) begin
            cnt     <= '0;
            smode_q <= signed_mode;
            ref_q   <= full_mul(op_a, op_b, signed_mode);
        end else if (busy) begin
            cnt <= cnt + 4'd1;
        end
    end

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (product == '0 && !busy && !done));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4
    busy_low_at_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(product));

    // R3
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (cnt == (smode_q ? 4'd6 : 4'd4)));

    // R1 R2 R6 R7
    value_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (product == ref_q));
endmodule

bind bmul16_iter bmul16_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .signed_mode (signed_mode),
    .op_a        (op_a),
    .op_b        (op_b),
    .busy        (busy),
    .done        (done),
    .product     (product)
);

// File: tb/bmul16_iter_test.sv
module bmul16_iter_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        signed_mode = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        busy, done;
    logic [31:0] product;

    int tests = 0;
    int fails = 0;

    bmul16_iter uut (
        .clk(clk), .rst(rst), .start(start), .signed_mode(signed_mode),
        .op_a(op_a), .op_b(op_b), .busy(busy), .done(done), .product(product)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] ref_mul(input logic [15:0] a, input logic [15:0] b,
                                            input logic s);
        longint x, y;
        x = s ? longint'($signed(a)) : longint'(a);
        y = s ? longint'($signed(b)) : longint'(b);
        return 32'(x * y);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural reference: remaining cycles, pending result
    int          m_left = 0;
    logic        m_busy = 0, m_done = 0, armed = 0;
    logic [31:0] m_prod = 0, m_pend = 0;

    always @(posedge clk) begin
        armed = 1'b1;
        if (rst) begin
            m_busy = 0; m_done = 0; m_prod = 0; m_left = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    m_busy = 0; m_done = 1; m_prod = m_pend;
                end
            end else if (start) begin
                m_busy = 1;
                m_left = signed_mode ? 6 : 4;
                m_pend = ref_mul(op_a, op_b, signed_mode);
            end
        end
    end

    always @(negedge clk) begin
        if (armed) begin
            check("R4 busy", 32'(busy), 32'(m_busy));
            check("R3 done", 32'(done), 32'(m_done));
            if (!m_busy) check("R5 product idle", product, m_prod);
        end
    end

    task automatic issue(input logic [15:0] a, input logic [15:0] b, input logic s);
        @(negedge clk);
        op_a = a; op_b = b; signed_mode = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R7: scramble inputs after capture
        op_a = ~a; op_b = a ^ b; signed_mode = ~s;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        for (int i = 0; i < 12; i++) begin
            if (done) break;
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_op(input logic [15:0] a, input logic [15:0] b, input logic s);
        int n;
        issue(a, b, s);
        wait_done(n);
        check("R3 latency", 32'(n), s ? 32'd6 : 32'd4);
        check(s ? "R2 signed product" : "R1 unsigned product", product, ref_mul(a, b, s));
    endtask

    initial begin
        logic [15:0] corners [5];
        int n;
        corners = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        check("R8 reset product", product, 32'h0);
        check("R8 reset busy", 32'(busy), 32'h0);

        for (int m = 0; m < 2; m++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++)
                    run_op(corners[i], corners[j], m[0]);

        for (int k = 0; k < 200; k++)
            run_op(16'($urandom), 16'($urandom), k[0]);

        // R6: start while busy with other operands
        issue(16'h8001, 16'h1234, 1'b1);
        @(negedge clk);
        op_a = 16'h0003; op_b = 16'h0005; signed_mode = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(n);
        check("R6 latency kept", 32'(n), 32'd4);
        check("R6 product kept", product, ref_mul(16'h8001, 16'h1234, 1'b1));

        // R5: result held across idle cycles
        repeat (5) @(negedge clk);
        check("R5 hold", product, ref_mul(16'h8001, 16'h1234, 1'b1));

        // R8: reset mid-operation
        issue(16'hFFFF, 16'h8000, 1'b1);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R8 mid-op product", product, 32'h0);
        check("R8 mid-op busy", 32'(busy), 32'h0);
        run_op(16'h1234, 16'hABCD, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule